// File: doc/BRIEF.md
# Dual-Lane Multiply-Accumulate Unit

This unit executes a packed multiply-accumulate operation for a 32-bit processor pipeline. When the decoder raises the issue strobe, the unit takes two 32-bit source words. It treats each word as two 16-bit halfwords. The lower halves of the two words are multiplied together, and so are the upper halves. Each of the two products is added into its own 40-bit accumulator.

The unit has two stages. The first stage registers the operands and the issue flag. The second stage reads both accumulators, adds the registered products and writes the results back. Because of this split, a new operation can be issued on every cycle and none is lost. A synchronous clear zeroes both accumulators. Both accumulator values are always visible on read ports.

Top module: `dual_mac_unit`

## Requirements
- R1: The reset is synchronous and active-low. One rising edge with `rst_n` low sets both accumulators to zero. It also discards any operation captured in the first stage, so that operation never reaches the accumulators.
- R2: `acc_lo` gains the product of `src_a[15:0]` and `src_b[15:0]`.
- R3: `acc_hi` gains the product of `src_a[31:16]` and `src_b[31:16]`. The lower halfwords have no effect on this lane.
- R4: Operands sampled with `issue_valid` high at rising edge N appear in the accumulators after edge N+1. After edge N itself the accumulators still hold their old values.
- R5: A single issue updates both accumulators on the same edge.
- R6: Both products are unsigned 16x16 values, zero-extended to 40 bits. Accumulation wraps modulo 2^40; for example, 0x8000 times 0x8000 adds 0x0040000000.
- R7: Issues on consecutive cycles are each accumulated exactly once, with no lost update.
- R8: `acc_clear` sampled high at an edge makes both accumulators zero after that edge. This takes priority over an update landing on the same edge, which is dropped. An operation issued on that same clear edge still lands on the following edge.
- R9: With no operation in the second stage and no clear, both accumulators keep their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| issue_valid | input | 1 | Packed MAC operation issued this cycle |
| src_a | input | 32 | First source word, two halfwords |
| src_b | input | 32 | Second source word, two halfwords |
| acc_clear | input | 1 | Synchronous clear of both accumulators |
| acc_lo | output | 40 | Accumulator of the lower-halfword lane |
| acc_hi | output | 40 | Accumulator of the upper-halfword lane |

## Verification
Both accumulators are exposed directly on ports, so a wrong internal value shows up after the edge where it is written. If a stage-one register is lost or stale, one accumulator shows a wrong sum one edge after the issue edge. A swapped halfword slice or an unwanted sign extension would change every later value of the affected lane. A clear or reset that fails to win over a pending update leaves a nonzero value visible right after that edge. The scoreboard compares both accumulators after every cycle, so any such fault is reported within one cycle of its cause.

// File: rtl/dmac_pkg.sv
// Shared constants for the dual-lane multiply-accumulate unit.
// Assumes exactly two lanes, split by halfword of each source word.
package dmac_pkg;
    localparam int LANES   = 2;
    localparam int LANE_LO = 0;
    localparam int LANE_HI = 1;
endpackage

// File: rtl/dmac_issue_reg.sv
// Stage one: registers the issue flag and both source words.
// Assumes the synchronous reset must drop any captured operation.
// Operands are loaded only on an issue, so idle cycles do not toggle them.
module dmac_issue_reg #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              issue_valid,
    input  logic [DATA_W-1:0] src_a,
    input  logic [DATA_W-1:0] src_b,
    output logic              stg_valid,
    output logic [DATA_W-1:0] stg_a,
    output logic [DATA_W-1:0] stg_b
);
    // Issue flag of the captured operation; reset discards it.
    always_ff @(posedge clk) begin
        if (!rst_n) stg_valid <= 1'b0;
        else        stg_valid <= issue_valid;
    end

    // Operand capture, enabled by the issue strobe.
    always_ff @(posedge clk) begin
        if (issue_valid) begin
            stg_a <= src_a;
            stg_b <= src_b;
        end
    end
endmodule

// File: rtl/dmac_lane.sv
// Stage two of one lane: unsigned LANE_W x LANE_W multiply, then add
// into an ACC_W accumulator that wraps on overflow.
// Assumes ACC_W >= 2*LANE_W. Clear has priority over the update.
module dmac_lane #(
    parameter int LANE_W = 16,
    parameter int ACC_W  = 40
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              upd,
    input  logic [LANE_W-1:0] op_a,
    input  logic [LANE_W-1:0] op_b,
    output logic [ACC_W-1:0]  acc
);
    localparam int PROD_W = 2 * LANE_W;

    logic [PROD_W-1:0] prod;
    logic [ACC_W-1:0]  prod_ext;

    // Unsigned product, zero-extended to the accumulator width.
    always_comb begin
        prod     = op_a * op_b;
        prod_ext = ACC_W'(prod);
    end

    // Accumulator register: reset and clear first, then add, else hold.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) acc <= '0;
        else if (upd)        acc <= acc + prod_ext;
    end
endmodule

// File: rtl/dual_mac_unit.sv
// Top of the dual-lane multiply-accumulate unit.
// Stage one captures the operands. Stage two runs one dmac_lane per
// halfword, and both lanes update on the same edge.
// Assumes the decoder raises issue_valid for at most one operation per cycle.
module dual_mac_unit #(
    parameter int LANE_W = 16,
    parameter int ACC_W  = 40,
    parameter int DATA_W = dmac_pkg::LANES * LANE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              issue_valid,
    input  logic [DATA_W-1:0] src_a,
    input  logic [DATA_W-1:0] src_b,
    input  logic              acc_clear,
    output logic [ACC_W-1:0]  acc_lo,
    output logic [ACC_W-1:0]  acc_hi
);
    import dmac_pkg::*;

    logic                   stg_valid;
    logic [DATA_W-1:0]      stg_a;
    logic [DATA_W-1:0]      stg_b;
    logic [LANES*ACC_W-1:0] acc_all;

    dmac_issue_reg #(.DATA_W(DATA_W)) u_issue (
        .clk         (clk),
        .rst_n       (rst_n),
        .issue_valid (issue_valid),
        .src_a       (src_a),
        .src_b       (src_b),
        .stg_valid   (stg_valid),
        .stg_a       (stg_a),
        .stg_b       (stg_b)
    );

    // One lane per halfword; lane i uses bits [i*LANE_W +: LANE_W].
    for (genvar i = 0; i < LANES; i++) begin : g_lane
        dmac_lane #(.LANE_W(LANE_W), .ACC_W(ACC_W)) u_lane (
            .clk   (clk),
            .rst_n (rst_n),
            .clear (acc_clear),
            .upd   (stg_valid),
            .op_a  (stg_a[i*LANE_W +: LANE_W]),
            .op_b  (stg_b[i*LANE_W +: LANE_W]),
            .acc   (acc_all[i*ACC_W +: ACC_W])
        );
    end

    // Read ports taken from the lane accumulators.
    always_comb begin
        acc_lo = acc_all[LANE_LO*ACC_W +: ACC_W];
        acc_hi = acc_all[LANE_HI*ACC_W +: ACC_W];
    end
endmodule

// File: rtl/dmac_unit_chk.sv
// Checker for dual_mac_unit, attached with bind. It keeps its own copy of
// the issued operation one cycle old and checks the accumulators at the ports.
module dmac_unit_chk #(
    parameter int LANE_W = 16,
    parameter int ACC_W  = 40,
    parameter int DATA_W = 2 * LANE_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic              issue_valid,
    input logic [DATA_W-1:0] src_a,
    input logic [DATA_W-1:0] src_b,
    input logic              acc_clear,
    input logic [ACC_W-1:0]  acc_lo,
    input logic [ACC_W-1:0]  acc_hi
);
    logic              seen_v;
    logic [DATA_W-1:0] seen_a;
    logic [DATA_W-1:0] seen_b;
    logic [2*LANE_W-1:0] p_lo;
    logic [2*LANE_W-1:0] p_hi;
    logic [ACC_W-1:0]  want_lo;
    logic [ACC_W-1:0]  want_hi;

    // Checker copy of the operation issued on the previous edge.
    always_ff @(posedge clk) begin
        seen_v <= rst_n && issue_valid;
        seen_a <= src_a;
        seen_b <= src_b;
    end

    // Next sums expected if that operation lands.
    always_comb begin
        p_lo    = seen_a[LANE_W-1:0] * seen_b[LANE_W-1:0];
        p_hi    = seen_a[DATA_W-1:LANE_W] * seen_b[DATA_W-1:LANE_W];
        want_lo = acc_lo + ACC_W'(p_lo);
        want_hi = acc_hi + ACC_W'(p_hi);
    end

    // R1: right after reset is released, both accumulators are zero
    a_r1_reset_zero: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (acc_lo == '0 && acc_hi == '0));

    // R8: clear empties both lanes, even over a landing update
    a_r8_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
        acc_clear |=> (acc_lo == '0 && acc_hi == '0));

    // R5: a landing operation updates both lanes on the same edge
    a_r5_both_lanes: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_v && !acc_clear) |=> (acc_lo == $past(want_lo) && acc_hi == $past(want_hi)));

    // R9: without a landing operation or clear, both lanes hold
    a_r9_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (!seen_v && !acc_clear) |=> ($stable(acc_lo) && $stable(acc_hi)));
endmodule

bind dual_mac_unit dmac_unit_chk #(.LANE_W(LANE_W), .ACC_W(ACC_W), .DATA_W(DATA_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .issue_valid (issue_valid),
    .src_a       (src_a),
    .src_b       (src_b),
    .acc_clear   (acc_clear),
    .acc_lo      (acc_lo),
    .acc_hi      (acc_hi)
);

// File: tb/dual_mac_unit_tb.sv
`timescale 1ns/1ps
// Scoreboard bench: the step task drives one cycle of stimulus and advances
// a reference model. It queues the values expected after the next edge.
// A monitor pops those values and compares them against both ports.
module dual_mac_unit_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        issue_valid = 1'b0;
    logic [31:0] src_a = '0;
    logic [31:0] src_b = '0;
    logic        acc_clear = 1'b0;
    logic [39:0] acc_lo;
    logic [39:0] acc_hi;

    int errors = 0;
    int checks = 0;
    int cyc = 0;
    bit done = 1'b0;

    typedef struct {
        int          due;
        logic [39:0] lo;
        logic [39:0] hi;
        string       req;
    } exp_t;
    exp_t sb[$];

    // Reference model state.
    logic [39:0] m_lo = '0, m_hi = '0, p_lo = '0, p_hi = '0;
    bit          p_v = 1'b0;

    always #2.5 clk = ~clk;

    dual_mac_unit u_dut (
        .clk(clk), .rst_n(rst_n), .issue_valid(issue_valid),
        .src_a(src_a), .src_b(src_b), .acc_clear(acc_clear),
        .acc_lo(acc_lo), .acc_hi(acc_hi)
    );

    always @(posedge clk) cyc <= cyc + 1;

    // Drive one cycle, advance the model, queue the expected result.
    task automatic step(input bit rst, input bit v, input bit clr,
                        input logic [31:0] a, input logic [31:0] b, input string req);
        exp_t e;
        @(negedge clk);
        rst_n = rst; issue_valid = v; acc_clear = clr; src_a = a; src_b = b;
        if (!rst) begin
            m_lo = '0; m_hi = '0; p_v = 1'b0;
        end else begin
            if (clr) begin
                m_lo = '0; m_hi = '0;
            end else if (p_v) begin
                m_lo = m_lo + p_lo; m_hi = m_hi + p_hi;
            end
            p_v  = v;
            p_lo = 40'(a[15:0]) * 40'(b[15:0]);
            p_hi = 40'(a[31:16]) * 40'(b[31:16]);
        end
        e.due = cyc + 1; e.lo = m_lo; e.hi = m_hi; e.req = req;
        sb.push_back(e);
    endtask

    // Monitor: compare every due item, away from the active edge.
    always @(negedge clk) begin
        while (sb.size() > 0 && sb[0].due <= cyc) begin
            exp_t e;
            e = sb.pop_front();
            checks++;
            if (acc_lo !== e.lo || acc_hi !== e.hi) begin
                errors++;
                $display("FAIL %s cycle %0d: lo=%h hi=%h expected lo=%h hi=%h",
                         e.req, cyc, acc_lo, acc_hi, e.lo, e.hi);
            end
        end
    end

    initial begin
        // R1: reset with an issue held high must leave zeros
        step(0, 1, 0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, "R1");
        step(0, 1, 0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, "R1");
        step(1, 0, 0, 32'h0, 32'h0, "R1");
        // R4: not visible after the capture edge; R2 R3 R5 one edge later
        step(1, 1, 0, 32'h0007_0003, 32'h0005_0009, "R4");
        step(1, 0, 0, 32'h0, 32'h0, "R2 R3 R5 lo=27 hi=35");
        // R9: idle cycles hold, even with noise on the operands
        for (int i = 0; i < 3; i++) step(1, 0, 0, 32'hDEAD_BEEF, 32'h1234_5678, "R9");
        // R3: only the upper halfwords feed acc_hi
        step(1, 1, 0, 32'h1234_0000, 32'h0002_0000, "R3");
        step(1, 0, 0, 32'h0, 32'h0, "R3");
        // R6: unsigned product 0x8000*0x8000
        step(1, 1, 0, 32'h8000_8000, 32'h8000_0001, "R6");
        step(1, 0, 0, 32'h0, 32'h0, "R6");
        // R7: back-to-back random issues
        for (int i = 0; i < 200; i++) step(1, 1, 0, $urandom, $urandom, "R7");
        step(1, 0, 0, 32'h0, 32'h0, "R7");
        // R7: issues interleaved with idle cycles
        for (int i = 0; i < 60; i++) step(1, 1'($urandom), 0, $urandom, $urandom, "R7");
        // R6: wrap modulo 2^40 after a clear
        step(1, 0, 1, 32'h0, 32'h0, "R8");
        for (int i = 0; i < 300; i++) step(1, 1, 0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, "R6");
        step(1, 0, 0, 32'h0, 32'h0, "R6");
        // R8: clear drops the landing update but keeps the issue on the clear edge
        step(1, 1, 0, 32'h0011_0022, 32'h0033_0044, "R8");
        step(1, 1, 1, 32'h0002_0003, 32'h0004_0005, "R8");
        step(1, 0, 0, 32'h0, 32'h0, "R8 lo=15 hi=8");
        step(1, 0, 0, 32'h0, 32'h0, "R9");
        // R1: mid-run reset drops a captured operation
        step(1, 1, 0, 32'h0100_0100, 32'h0100_0100, "R1");
        step(0, 0, 0, 32'h0, 32'h0, "R1");
        step(1, 0, 0, 32'h0, 32'h0, "R1");
        step(1, 0, 0, 32'h0, 32'h0, "R1");
        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule